// File: doc/BRIEF.md
# PWM Bank Software Disable Control

This block holds the control and output gating for a six-channel motor-control PWM. A control register carries a master run enable, a load-ok bit, a reload flag, an interrupt enable and two bank-wide software disable bits. The channels are split into bank X (channels 0 to 3) and bank Y (channels 4 and 5). A separate mapping register chooses which channels a bank disable acts on. That mapping register accepts only one write after reset, so a stray write cannot undo a protection set up at boot.

The raw PWM waveforms come from an external counter and compare stage, which also supplies a one-cycle pulse at the start of each PWM period. Setting a bank disable drives the mapped channels to their inactive level of 0 straight away. Clearing the bit lets them run again only from the next period start, so no partial pulse appears. The same period-start pulse sets the reload flag, which raises an interrupt request when the interrupt enable is on. Software uses a simple read/write register bus with a one-bit address.

Top module: `pwm_bank_disable`

## Requirements
- R1: After reset both registers read 0, every pwm_out bit is 0 and irq is 0.
- R2: The control register sits at bus address 0 with run enable in bit 0, load-ok in bit 1, reload flag in bit 4, interrupt enable in bit 5, bank Y disable in bit 6 and bank X disable in bit 7. Bits 3:2 read 0. Run, load-ok, interrupt enable and both disables read back the value last written.
- R3: While run enable is 0, all pwm_out bits are 0. While run enable is 1 and no disable acts, pwm_out equals pwm_in.
- R4: The mapping register sits at bus address 1. Bits 3:0 select channels 0 to 3 for bank X, and bit 4 selects both channels 4 and 5 for bank Y. Bits 7:5 read 0.
- R5: The mapping register takes only its first write after reset. Later writes leave it unchanged.
- R6: A write that sets a bank disable bit drives that bank's mapped channels to 0 from the cycle after the write edge. Unmapped channels and the other bank keep passing pwm_in.
- R7: After a bank disable bit is cleared, its mapped channels stay 0 until the first cyc_start pulse sampled after the clearing edge. A pulse at the same edge as the clearing write does not count. The channels follow pwm_in again from the cycle after that pulse.
- R8: A cyc_start pulse sets the reload flag at the next edge. Writing 1 to the flag bit has no effect.
- R9: A control write with bit 4 at 0 clears the reload flag only if a control read has returned the flag as 1 since it was set. Without that read the flag stays set. A cyc_start pulse at the same edge as the clearing write keeps the flag set.
- R10: irq is 1 exactly when both the reload flag and the interrupt enable are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | Register select: 0 control, 1 mapping |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high, else 0 |
| cyc_start | input | 1 | One-cycle pulse at each PWM period start |
| pwm_in | input | 6 | Raw PWM channel waveforms |
| pwm_out | output | 6 | Gated PWM outputs, inactive level 0 |
| irq | output | 1 | Interrupt request |

## Verification
A disable that is held too long or released too early shows on pwm_out in the first cycle after the clearing write or the period pulse. The bench therefore samples the outputs in that cycle and in the cycle after the pulse. A mapping register that accepts a second write changes which channels a later disable forces, and a read of address 1 shows it at once. Bad reload-flag or arming state shows on irq and on bit 4 of a control read right after the write that should or should not have cleared it. Reset-state faults show on the first read after reset is released.

// File: rtl/pwm_gate_pkg.sv
package pwm_gate_pkg;
  localparam int DW = 8;

  localparam int CB_RUN  = 0;
  localparam int CB_LDOK = 1;
  localparam int CB_FLAG = 4;
  localparam int CB_IE   = 5;
  localparam int CB_DISY = 6;
  localparam int CB_DISX = 7;

  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_MAP  = 1'b1;

  typedef struct packed {
    logic dis_x;
    logic dis_y;
    logic ie;
    logic flag;
    logic ldok;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_rst_sync.sv
module pwm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_ctl_regs.sv
module pwm_ctl_regs
  import pwm_gate_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [DW-1:0] wdata,
  input  logic          cyc_start,
  output ctrl_t         ctrl_o,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  ctrl_t ctrl_q, ctrl_d;
  logic  armed_q, armed_d;
  logic  flag_clr;

  always_comb begin
    ctrl_d   = ctrl_q;
    flag_clr = wr_en && !wdata[CB_FLAG] && armed_q && ctrl_q.flag;
    if (wr_en) begin
      ctrl_d.run   = wdata[CB_RUN];
      ctrl_d.ldok  = wdata[CB_LDOK];
      ctrl_d.ie    = wdata[CB_IE];
      ctrl_d.dis_y = wdata[CB_DISY];
      ctrl_d.dis_x = wdata[CB_DISX];
    end
    if (cyc_start)     ctrl_d.flag = 1'b1;
    else if (flag_clr) ctrl_d.flag = 1'b0;

    if (!ctrl_d.flag)                armed_d = 1'b0;
    else if (rd_en && ctrl_q.flag)   armed_d = 1'b1;
    else                             armed_d = armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[CB_RUN]  = ctrl_q.run;
    rdata_o[CB_LDOK] = ctrl_q.ldok;
    rdata_o[CB_FLAG] = ctrl_q.flag;
    rdata_o[CB_IE]   = ctrl_q.ie;
    rdata_o[CB_DISY] = ctrl_q.dis_y;
    rdata_o[CB_DISX] = ctrl_q.dis_x;
  end

  assign ctrl_o = ctrl_q;
  assign irq_o  = ctrl_q.flag & ctrl_q.ie;

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |=> ctrl_q.flag);

  // R9
  flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ctrl_q.flag) |-> ($past(armed_q) && $past(wr_en) && !$past(cyc_start)));
endmodule

// File: rtl/pwm_map_reg.sv
module pwm_map_reg #(
  parameter int MW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [MW-1:0] wdata,
  output logic [MW-1:0] map_o
);
  logic [MW-1:0] map_q, map_d;
  logic          done_q, done_d;
  logic          take;

  always_comb begin
    take   = wr_en && !done_q;
    map_d  = take ? wdata : map_q;
    done_d = done_q | wr_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q  <= '0;
      done_q <= 1'b0;
    end else begin
      map_q  <= map_d;
      done_q <= done_d;
    end
  end

  assign map_o = map_q;

  // R5
  map_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(map_q));
endmodule

// File: rtl/pwm_bank_gate.sv
module pwm_bank_gate #(
  parameter int NCH = 6,
  parameter int NX  = 4,
  localparam int MW = NX + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run,
  input  logic           dis_x,
  input  logic           dis_y,
  input  logic [MW-1:0]  map,
  input  logic           cyc_start,
  input  logic [NCH-1:0] pwm_in,
  output logic [NCH-1:0] pwm_out
);
  localparam int NB = 2;

  logic [NB-1:0] dis_b;
  logic [NB-1:0] hold_q, hold_d;
  logic [NB-1:0] blk;

  assign dis_b = {dis_y, dis_x};

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_comb begin
      hold_d[b] = dis_b[b] | (hold_q[b] & ~cyc_start);
      blk[b]    = dis_b[b] | hold_q[b];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q[b] <= 1'b0;
      else        hold_q[b] <= hold_d[b];
    end

    // R7
    hold_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hold_q[b]) |-> ($past(cyc_start) && !$past(dis_b[b])));
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int BANK = (c < NX) ? 0 : 1;
    localparam int MBIT = (c < NX) ? c : NX;
    always_comb pwm_out[c] = run & pwm_in[c] & ~(blk[BANK] & map[MBIT]);
  end
endmodule

// File: rtl/pwm_bank_disable.sv
module pwm_bank_disable
  import pwm_gate_pkg::*;
#(
  parameter int NCH = 6,
  parameter int NX  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_addr,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic           cyc_start,
  input  logic [NCH-1:0] pwm_in,
  output logic [NCH-1:0] pwm_out,
  output logic           irq
);
  localparam int MW = NX + 1;

  logic          rst_n_i;
  logic          ctrl_wr, ctrl_rd, map_wr;
  ctrl_t         ctrl;
  logic [DW-1:0] ctrl_rdata;
  logic [MW-1:0] map;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
  assign ctrl_rd = bus_rd && (bus_addr == ADDR_CTRL);
  assign map_wr  = bus_wr && (bus_addr == ADDR_MAP);

  pwm_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  pwm_ctl_regs u_ctl (
    .clk(clk), .rst_n(rst_n_i), .wr_en(ctrl_wr), .rd_en(ctrl_rd),
    .wdata(bus_wdata), .cyc_start(cyc_start), .ctrl_o(ctrl),
    .rdata_o(ctrl_rdata), .irq_o(irq)
  );

  pwm_map_reg #(.MW(MW)) u_map (
    .clk(clk), .rst_n(rst_n_i), .wr_en(map_wr),
    .wdata(bus_wdata[MW-1:0]), .map_o(map)
  );

  pwm_bank_gate #(.NCH(NCH), .NX(NX)) u_gate (
    .clk(clk), .rst_n(rst_n_i), .run(ctrl.run), .dis_x(ctrl.dis_x),
    .dis_y(ctrl.dis_y), .map(map), .cyc_start(cyc_start),
    .pwm_in(pwm_in), .pwm_out(pwm_out)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_MAP) bus_rdata[MW-1:0] = map;
      else                      bus_rdata = ctrl_rdata;
    end
  end

  // R3
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !ctrl.run |-> (pwm_out == '0));
endmodule

// File: tb/pwm_bank_disable_test.sv
module pwm_bank_disable_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_addr, bus_wr, bus_rd, cyc_start;
  logic [7:0] bus_wdata, bus_rdata;
  logic [5:0] pwm_in, pwm_out;
  logic       irq;
  int         n_chk = 0, n_fail = 0;

  pwm_bank_disable uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cyc_start(cyc_start), .pwm_in(pwm_in), .pwm_out(pwm_out), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic a, input logic [7:0] d, input logic pulse);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cyc_start = pulse;
    @(negedge clk);
    bus_wr = 1'b0; cyc_start = 1'b0;
  endtask

  task automatic bread(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    cyc_start = 1'b1;
    @(negedge clk);
    cyc_start = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    pwm_in = 6'h3F;
    #1;
    check("R1 pwm_out", pwm_out, 0);
    check("R1 irq", irq, 0);
    bread(1'b0, d); check("R1 ctrl", d, 8'h00);
    bread(1'b1, d); check("R1 map", d, 8'h00);
  endtask

  task automatic t_flag_write1();
    logic [7:0] d;
    bwrite(1'b0, 8'h10, 1'b0);
    bread(1'b0, d); check("R8 write 1 to flag ignored", d, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    bwrite(1'b0, 8'hEF, 1'b0);
    bread(1'b0, d); check("R2 readback", d, 8'hE3);
    #1 check("R10 irq with flag 0", irq, 0);
    bwrite(1'b0, 8'h12, 1'b0);
    bread(1'b0, d); check("R2 ldok only", d, 8'h02);
    pulse();
  endtask

  task automatic t_run();
    pwm_in = 6'h3F;
    bwrite(1'b0, 8'h10, 1'b0);
    #1 check("R3 run off", pwm_out, 0);
    bwrite(1'b0, 8'h11, 1'b0);
    #1 check("R3 pass 3F", pwm_out, 6'h3F);
    pwm_in = 6'h2A;
    #1 check("R3 pass 2A", pwm_out, 6'h2A);
    pwm_in = 6'h3F;
  endtask

  task automatic t_map();
    logic [7:0] d;
    bwrite(1'b1, 8'hF5, 1'b0);
    bread(1'b1, d); check("R4 map first write", d, 8'h15);
    bwrite(1'b1, 8'h0A, 1'b0);
    bread(1'b1, d); check("R5 second write ignored", d, 8'h15);
  endtask

  task automatic t_dis();
    bwrite(1'b0, 8'h91, 1'b0);
    #1 check("R6 bank X forced", pwm_out, 6'h3A);
    bwrite(1'b0, 8'hD1, 1'b0);
    #1 check("R6 both banks forced", pwm_out, 6'h0A);
    bwrite(1'b0, 8'h11, 1'b0);
    #1 check("R7 held after clear", pwm_out, 6'h0A);
    repeat (3) @(negedge clk);
    #1 check("R7 held before pulse", pwm_out, 6'h0A);
    pulse();
    #1 check("R7 released after pulse", pwm_out, 6'h3F);
    bwrite(1'b0, 8'h91, 1'b0);
    bwrite(1'b0, 8'h11, 1'b1);
    #1 check("R7 coincident pulse ignored", pwm_out, 6'h3A);
    pulse();
    #1 check("R7 released on next pulse", pwm_out, 6'h3F);
  endtask

  task automatic t_flag();
    logic [7:0] d;
    bwrite(1'b0, 8'h01, 1'b0);
    bread(1'b0, d); check("R9 no clear without read", d, 8'h11);
    bwrite(1'b0, 8'h31, 1'b0);
    #1 check("R10 irq on", irq, 1);
    bwrite(1'b0, 8'h21, 1'b0);
    #1 check("R10 irq off after clear", irq, 0);
    bread(1'b0, d); check("R9 flag cleared", d, 8'h21);
    pulse();
    #1 check("R8 flag set by pulse", irq, 1);
    bread(1'b0, d); check("R8 flag read", d, 8'h31);
    bwrite(1'b0, 8'h21, 1'b1);
    bread(1'b0, d); check("R9 pulse wins over clear", d, 8'h31);
    bwrite(1'b0, 8'h01, 1'b0);
    #1 check("R10 irq off with ie 0", irq, 0);
  endtask

  initial begin
    #(PERIOD*20000);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; cyc_start = 1'b0; pwm_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_flag_write1();
    t_regs();
    t_run();
    t_map();
    t_dis();
    t_flag();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule